// File: doc/BRIEF.md
# Lamp Fault Timeout Supervisor

This block watches a lamp-health input that sits high while every lamp in a backlight string is lit and drops low when one or more lamps fail to strike. It measures how long that input stays low, in steps of an external prescaled timebase tick (one step is meant to be about 7.8 ms), against an 8-bit programmable timeout code. When the low interval reaches the code, a sticky fault flag is set. The flag forces every dimming output low and stays set until the block is reset.

A code of zero turns the supervisor off, so operation carries on with the lamp input low. The timer counts only while the combined enable (master enable bit AND enable pin) is high. It clears whenever the lamp input recovers, the enable drops, or a new code is written, so only an unbroken low interval can trip the fault. The block also gates the per-channel dimming signals with their channel enables and produces a registered three-bit status word.

Top module: `lamp_fault_guard`

## Requirements
- R1: With the combined enable high and no fault, `pwm_o[i]` equals `pwm_raw_i[i] & chan_en_i[i]` sampled one clock earlier.
- R2: The combined enable is `master_en_i & enable_pin_i`. When it is low, every `pwm_o` bit is 0 on the next clock, and the timeout count restarts.
- R3: `lamp_ok_i` passes through a two-flop synchronizer. Only a cycle in which the synchronized level is low, the combined enable is high and `tick_i` is high advances the timer. With code N (1..255), `fault_o` rises after N such counted ticks in a row.
- R4: Once `fault_o` is high it stays high until `rst`, whatever `lamp_ok_i` does, and `pwm_o` is all zeros from the clock after it rises.
- R5: A timeout code of 0x00 never trips the fault, however long the lamp input stays low.
- R6: After reset the timeout code is 0x80, so the fault trips after 128 counted ticks.
- R7: A synchronized lamp level that returns high restarts the count from zero before the timeout is reached.
- R8: A write (`code_we_i` high) loads `code_i` and restarts the count, and a tick in the write cycle is not counted. A write never clears a latched fault.
- R9: `status_o` is registered one clock after its sources: bit 0 is the fault flag, bit 1 is the synchronized lamp level, and bit 2 is the combined enable.
- R10: After reset, `pwm_o`, `status_o` and `fault_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Timebase step pulse, one clock wide |
| lamp_ok_i | input | 1 | Asynchronous lamp-health level, high when all lamps are lit |
| master_en_i | input | 1 | Master enable bit |
| enable_pin_i | input | 1 | Enable pin level |
| code_we_i | input | 1 | Timeout code write strobe |
| code_i | input | 8 | Timeout code to load |
| chan_en_i | input | 8 | Per-channel enables |
| pwm_raw_i | input | 8 | Per-channel dimming signals before gating |
| pwm_o | output | 8 | Gated dimming outputs, registered |
| fault_o | output | 1 | Latched fault flag |
| status_o | output | 3 | {combined enable, synchronized lamp level, fault} |

## Verification
The hardest cases to reach are the near misses: low intervals that stop just short of the timeout because the lamp recovers, the enable drops or a new code is written. Each of these must leave the count empty, so that a second short interval does not carry over. The stimulus takes a small code (10) and drives low bursts a few ticks shorter than it, split by each kind of restart. It then drives one unbroken burst that does trip, so the same setup shows the fault both staying clear and being reached. The default code case simply holds the lamp low with a tick every cycle for about 140 cycles.

// File: rtl/lft_pkg.sv
package lft_pkg;
  typedef struct packed {
    logic en;
    logic lamp;
    logic fault;
  } lft_status_t;
endpackage

// File: rtl/lft_sync.sv
module lft_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{RST_VAL}};
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lft_timer.sv
module lft_timer #(
  parameter int CODE_W = 8,
  parameter logic [CODE_W-1:0] DEF_CODE = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              lamp_ok_i,
  input  logic              en_i,
  input  logic              code_we_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              fault_o,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] ONE = CODE_W'(1);

  logic [CODE_W-1:0] code_q, cnt_q;
  logic              fault_q;
  logic              low_run, step;

  assign low_run = !lamp_ok_i && en_i;
  assign step    = low_run && tick_i && (code_q != '0) && !fault_q && !code_we_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q  <= DEF_CODE;
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      if (code_we_i) code_q <= code_i;
      if (code_we_i || !low_run) cnt_q <= '0;
      else if (step)             cnt_q <= cnt_q + ONE;
      if (step && (cnt_q == code_q - ONE)) fault_q <= 1'b1;
    end
  end

  assign fault_o = fault_q;
  assign code_o  = code_q;
endmodule

// File: rtl/lft_gate.sv
module lft_gate #(
  parameter int N_CH = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            allow_i,
  input  logic [N_CH-1:0] raw_i,
  input  logic [N_CH-1:0] chan_en_i,
  output logic [N_CH-1:0] pwm_o
);
  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) pwm_o[g] <= 1'b0;
      else     pwm_o[g] <= allow_i & chan_en_i[g] & raw_i[g];
    end
  end
endmodule

// File: rtl/lamp_fault_guard.sv
module lamp_fault_guard
  import lft_pkg::*;
#(
  parameter int N_CH = 8,
  parameter int CODE_W = 8,
  parameter logic [CODE_W-1:0] DEF_CODE = 8'h80,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              lamp_ok_i,
  input  logic              master_en_i,
  input  logic              enable_pin_i,
  input  logic              code_we_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [N_CH-1:0]   chan_en_i,
  input  logic [N_CH-1:0]   pwm_raw_i,
  output logic [N_CH-1:0]   pwm_o,
  output logic              fault_o,
  output logic [2:0]        status_o
);
  logic              lamp_s;
  logic              en_all;
  logic              fault_w;
  logic [CODE_W-1:0] code_w;
  lft_status_t       stat_q;

  assign en_all = master_en_i & enable_pin_i;

  lft_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d_i(lamp_ok_i), .q_o(lamp_s)
  );

  lft_timer #(.CODE_W(CODE_W), .DEF_CODE(DEF_CODE)) u_timer (
    .clk(clk), .rst(rst), .tick_i(tick_i), .lamp_ok_i(lamp_s),
    .en_i(en_all), .code_we_i(code_we_i), .code_i(code_i),
    .fault_o(fault_w), .code_o(code_w)
  );

  lft_gate #(.N_CH(N_CH)) u_gate (
    .clk(clk), .rst(rst), .allow_i(en_all & ~fault_w),
    .raw_i(pwm_raw_i), .chan_en_i(chan_en_i), .pwm_o(pwm_o)
  );

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= '{en: en_all, lamp: lamp_s, fault: fault_w};
  end

  assign status_o = stat_q;
  assign fault_o  = fault_w;
endmodule

// File: rtl/lft_checker.sv
module lft_checker #(
  parameter int N_CH = 8,
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_i,
  input logic              master_en_i,
  input logic              enable_pin_i,
  input logic [N_CH-1:0]   pwm_o,
  input logic              fault_o,
  input logic [2:0]        status_o,
  input logic [CODE_W-1:0] code_w
);
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
    fault_o |=> fault_o); // R4
  AST_FAULT_BLANKS: assert property (@(posedge clk) disable iff (rst)
    fault_o |=> (pwm_o == '0)); // R4
  AST_ENABLE_GATES: assert property (@(posedge clk) disable iff (rst)
    !(master_en_i && enable_pin_i) |=> (pwm_o == '0)); // R2
  AST_ZERO_CODE_SAFE: assert property (@(posedge clk) disable iff (rst)
    ((code_w == '0) && !fault_o) |=> !fault_o); // R5
  AST_TRIP_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    (!fault_o && !tick_i) |=> !fault_o); // R3
  AST_STATUS_FAULT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status_o[0] == $past(fault_o))); // R9
endmodule

bind lamp_fault_guard lft_checker #(.N_CH(N_CH), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .tick_i(tick_i), .master_en_i(master_en_i),
  .enable_pin_i(enable_pin_i), .pwm_o(pwm_o), .fault_o(fault_o),
  .status_o(status_o), .code_w(code_w)
);

// File: tb/lamp_fault_guard_bench.sv
`timescale 1ns/1ps
module lamp_fault_guard_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0, lamp_ok = 1'b1, m_en = 1'b1, p_en = 1'b1;
  logic       we = 1'b0;
  logic [7:0] code = 8'h00, chan_en = 8'hFF, raw = 8'h00;
  logic [7:0] pwm;
  logic       fault;
  logic [2:0] status;

  int n_cmp = 0, n_bad = 0;
  bit tick_on = 1'b1;
  bit live = 1'b0;
  logic [7:0] lfsr = 8'h5A;

  always #10 clk = ~clk;

  lamp_fault_guard u_lamp_fault_guard (
    .clk(clk), .rst(rst), .tick_i(tick), .lamp_ok_i(lamp_ok),
    .master_en_i(m_en), .enable_pin_i(p_en), .code_we_i(we), .code_i(code),
    .chan_en_i(chan_en), .pwm_raw_i(raw), .pwm_o(pwm), .fault_o(fault),
    .status_o(status)
  );

  // behavioural reference
  logic  lamp_hist[$];
  int    m_code, m_elapsed;
  bit    m_fault;
  logic [7:0] m_pwm;
  logic [2:0] m_stat;

  always @(posedge clk) begin
    bit en, seen;
    if (rst) begin
      lamp_hist = '{1'b1, 1'b1};
      m_code = 128; m_elapsed = 0; m_fault = 0; m_pwm = 0; m_stat = 0;
    end else begin
      en   = m_en && p_en;
      seen = lamp_hist[0];
      m_pwm  = (en && !m_fault) ? (raw & chan_en) : 8'h00;
      m_stat = {en, seen, m_fault};
      if (we) begin
        m_elapsed = 0;
        m_code = code;
      end else if (seen || !en) begin
        m_elapsed = 0;
      end else if (tick && m_code != 0 && !m_fault) begin
        m_elapsed++;
        if (m_elapsed == m_code) m_fault = 1;
      end
      void'(lamp_hist.pop_front());
      lamp_hist.push_back(lamp_ok);
    end
  end

  always @(negedge clk) begin
    if (live) begin
      n_cmp += 3;
      if (pwm !== m_pwm) begin
        n_bad++; $display("FAIL R1 pwm_o act=%h exp=%h", pwm, m_pwm);
      end
      if (fault !== m_fault) begin
        n_bad++; $display("FAIL R3 fault_o act=%0b exp=%0b", fault, m_fault);
      end
      if (status !== m_stat) begin
        n_bad++; $display("FAIL R9 status_o act=%b exp=%b", status, m_stat);
      end
    end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    raw  = lfsr;
    tick = tick_on;
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++; $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; lamp_ok = 1'b1; we = 1'b0; m_en = 1'b1; p_en = 1'b1;
    cyc(3);
    rst = 1'b0;
  endtask

  task automatic write_code(logic [7:0] v);
    @(negedge clk); code = v; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  initial begin
    do_reset();
    live = 1'b1;
    chk("R10 pwm_o after reset", pwm, 8'h00);
    chk("R10 status_o after reset", {5'b0, status}, 8'h00);
    chk("R10 fault_o after reset", {7'b0, fault}, 8'h00);

    // R1 pass-through with several channel masks
    chan_en = 8'hFF; cyc(6);
    chan_en = 8'hAA; cyc(6);
    chan_en = 8'h0F; cyc(6);
    chan_en = 8'hFF;
    // R2 enable off
    m_en = 1'b0; cyc(2); chk("R2 master off pwm", pwm, 8'h00);
    m_en = 1'b1; p_en = 1'b0; cyc(2); chk("R2 pin off pwm", pwm, 8'h00);
    p_en = 1'b1; cyc(2);

    // R6 default code 0x80
    lamp_ok = 1'b0; cyc(120);
    chk("R6 no trip before 128 ticks", {7'b0, fault}, 8'h00);
    cyc(20);
    chk("R6 trip after 128 ticks", {7'b0, fault}, 8'h01);
    lamp_ok = 1'b1; cyc(10);
    chk("R4 fault held after lamp recovers", {7'b0, fault}, 8'h01);
    chk("R4 outputs blanked", pwm, 8'h00);

    // R5 code zero
    do_reset(); write_code(8'h00);
    lamp_ok = 1'b0; cyc(400);
    chk("R5 zero code never trips", {7'b0, fault}, 8'h00);
    lamp_ok = 1'b1; cyc(4);

    // R7 lamp recovery restarts, R3 ticks required
    write_code(8'd10);
    lamp_ok = 1'b0; cyc(7); lamp_ok = 1'b1; cyc(4);
    lamp_ok = 1'b0; cyc(7);
    chk("R7 recovery restarts count", {7'b0, fault}, 8'h00);
    lamp_ok = 1'b1; cyc(4);
    tick_on = 1'b0; lamp_ok = 1'b0; cyc(50);
    chk("R3 no tick no count", {7'b0, fault}, 8'h00);
    tick_on = 1'b1; cyc(20);
    chk("R3 continuous low trips", {7'b0, fault}, 8'h01);

    // R2 enable drop restarts
    do_reset(); write_code(8'd10);
    lamp_ok = 1'b0; cyc(9); p_en = 1'b0; cyc(3); p_en = 1'b1; cyc(7);
    chk("R2 enable drop restarts count", {7'b0, fault}, 8'h00);
    lamp_ok = 1'b1; cyc(4);

    // R8 write restarts, never clears
    lamp_ok = 1'b0; cyc(9); write_code(8'd10); cyc(8);
    chk("R8 write restarts count", {7'b0, fault}, 8'h00);
    cyc(6);
    chk("R8 trip after restart", {7'b0, fault}, 8'h01);
    write_code(8'h00); lamp_ok = 1'b1; cyc(6);
    chk("R8 write keeps fault", {7'b0, fault}, 8'h01);
    chk("R9 status reports fault", {7'b0, status[0]}, 8'h01);

    cyc(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule